// File: doc/BRIEF.md
# Page-Mode Asynchronous SRAM Controller

This block connects a clocked request port to an external asynchronous static RAM of 512K words by 16 bits. A request gives a word address, write data, two byte-lane enables, a read/write flag and a burst length. The controller then drives the memory's address lines, its two chip selects of opposite polarity, its output and write strobes, its two byte-lane strobes and a split data bus. The data bus has separate in, out and drive-enable signals. Each access time is a parameter counted in clock cycles.

The memory is divided into pages of 16 words. Within a page, a new word needs only the short page access time, provided the upper address bits and the selects do not move. A read burst therefore holds the page bits and steps the four low bits. Each word after the first in the same page is captured after the short wait. When the address crosses into a new page, that word waits the full access time. Each returned word gives a one-cycle valid strobe. Writes are single words. The port takes one request at a time through a ready/valid handshake. When the controller is idle, the memory is left deselected.

Top module: `pgsram_ctrl`

## Requirements
- R1: While the controller is ready for a request, the memory is deselected: sram_ce1_n=1, sram_ce2=0, sram_oe_n=1, sram_we_n=1, sram_lb_n=1, sram_ub_n=1, sram_dq_oe=0. This is also the state after reset.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from the next cycle until the operation, including any recovery or turnaround, has finished.
- R3: The first word of a read is captured T_RD_FULL clock edges after the accept edge. rsp_valid is high in the cycle after each capture edge.
- R4: Each later word of a read whose address stays in the same 16-word page (same address bits 18:4) is captured T_RD_PAGE edges after the previous capture. Only address bits 3:0 change, and they increase by one.
- R5: When the next read address has low bits 0 (a page boundary was crossed), that word is captured T_RD_FULL edges after the previous capture.
- R6: req_len holds the word count minus one (0 gives 1 word, 15 gives 16 words). A read returns exactly req_len+1 words, in increasing address order, starting at req_addr.
- R7: req_be[0] enables data bits 7:0 (sram_lb_n = ~req_be[0]) and req_be[1] enables bits 15:8 (sram_ub_n = ~req_be[1]). A disabled lane reads as zero on rsp_data, and a write leaves that lane of the memory unchanged.
- R8: A write holds sram_we_n low for exactly T_WR_PULSE cycles. During that time it drives the data, keeps sram_oe_n high, and gives exactly one write pulse, whatever req_len says. req_ready returns T_WR_CYCLE cycles after the accept edge.
- R9: sram_dq_oe is never 1 while sram_oe_n is 0. Only a write raises it, and only after sram_oe_n has been high for at least one cycle. After the last word of a read, req_ready returns T_TURN cycles after that word's capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address of the first word |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 low lane |
| req_len | input | 4 | Read burst word count minus one |
| rsp_valid | output | 1 | One-cycle strobe per returned read word |
| rsp_data | output | 16 | Returned word, disabled lanes zero |
| sram_addr | output | AW | Memory word address |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output strobe |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_lb_n | output | 1 | Active-low lower lane strobe |
| sram_ub_n | output | 1 | Active-low upper lane strobe |
| sram_dq_o | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | 16 | Data from the memory |

## Verification
The bench models the memory with its access windows. A word sampled before its full or page access time has passed comes back as a fixed garbage pattern, so any capture that comes too early shows up as a data mismatch. Page-aligned 16-word bursts exercise the fast in-page path. Bursts that start near the end of a page show whether the crossing restarts a full access. Single-lane writes and reads, followed by reads of both lanes, separate correct lane gating from whole-word writes. A write with a non-zero length, followed by a read of the next address, shows whether the length field leaked into writes. Random mixes of reads and writes over four neighbouring pages, with random lengths and lanes, exercise back-to-back turnaround.

// File: rtl/pgsram_ctrl.sv
module pgsram_ctrl #(
  parameter int AW         = 19,
  parameter int T_RD_FULL  = 9,
  parameter int T_RD_PAGE  = 3,
  parameter int T_WR_PULSE = 4,
  parameter int T_WR_CYCLE = 9,
  parameter int T_TURN     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  input  logic [3:0]    req_len,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce1_n,
  output logic          sram_ce2,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic          sram_lb_n,
  output logic          sram_ub_n,
  output logic [15:0]   sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [15:0]   sram_dq_i
);
  localparam int PB   = 4;
  localparam int CW   = 8;
  localparam int WREC = (T_WR_CYCLE > T_WR_PULSE + 1) ? T_WR_CYCLE - T_WR_PULSE : 1;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WRITE, S_WREC, S_TURN} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [3:0]    rem;
  logic [1:0]    be_q;
  logic          sel_q;
  logic [15:0]   lane_cap;

  assign req_ready  = (state == S_IDLE);
  assign sram_ce1_n = ~sel_q;
  assign sram_ce2   = sel_q;
  assign sram_lb_n  = ~be_q[0];
  assign sram_ub_n  = ~be_q[1];

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign lane_cap[8*i +: 8] = be_q[i] ? sram_dq_i[8*i +: 8] : 8'h00;
  end

  wire page_end = &sram_addr[PB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      rem        <= '0;
      be_q       <= '0;
      sel_q      <= 1'b0;
      sram_addr  <= '0;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_dq_o  <= '0;
      sram_dq_oe <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (state)
        S_IDLE: if (req_valid) begin
          sram_addr <= req_addr;
          be_q      <= req_be;
          sel_q     <= 1'b1;
          if (req_write) begin
            state      <= S_WRITE;
            cnt        <= CW'(T_WR_PULSE - 1);
            sram_we_n  <= 1'b0;
            sram_dq_o  <= req_wdata;
            sram_dq_oe <= 1'b1;
          end else begin
            state     <= S_READ;
            cnt       <= CW'(T_RD_FULL - 1);
            rem       <= req_len;
            sram_oe_n <= 1'b0;
          end
        end
        S_READ: if (cnt == '0) begin
          rsp_valid <= 1'b1;
          rsp_data  <= lane_cap;
          if (rem == '0) begin
            state     <= S_TURN;
            cnt       <= CW'(T_TURN - 1);
            sram_oe_n <= 1'b1;
            sel_q     <= 1'b0;
            be_q      <= '0;
          end else begin
            rem       <= rem - 1'b1;
            sram_addr <= sram_addr + 1'b1;
            cnt       <= page_end ? CW'(T_RD_FULL - 1) : CW'(T_RD_PAGE - 1);
          end
        end
        S_WRITE: if (cnt == '0) begin
          state     <= S_WREC;
          cnt       <= CW'(WREC - 1);
          sram_we_n <= 1'b1;
        end
        S_WREC: if (cnt == '0) begin
          state      <= S_IDLE;
          sram_dq_oe <= 1'b0;
          sel_q      <= 1'b0;
          be_q       <= '0;
        end
        S_TURN: if (cnt == '0) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_standby_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n &&
                   sram_lb_n && sram_ub_n && !sram_dq_oe));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_strobe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!sram_oe_n));

  a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && $past(!sram_oe_n) && sram_addr != $past(sram_addr))
      |-> sram_addr == AW'($past(sram_addr) + 1'b1));

  a_r5_page_change_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && $past(!sram_oe_n) && sram_addr[AW-1:PB] != $past(sram_addr[AW-1:PB]))
      |-> sram_addr[PB-1:0] == '0);

  a_r8_write_excludes_read: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && sram_dq_oe));

  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  a_r9_drive_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> $past(sram_oe_n));
endmodule

// File: tb/pgsram_ctrl_test.sv
`timescale 1ns/1ps
module pgsram_ctrl_test;
  localparam int AW = 19, TF = 9, TP = 3, TWP = 4, TWC = 9, TT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic [3:0] req_len = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [AW-1:0] sram_addr;
  logic sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n, sram_dq_oe;
  logic [15:0] sram_dq_o;
  logic [15:0] sram_dq_i = 16'hBAD0;

  always #2.5 clk = ~clk;

  pgsram_ctrl #(.AW(AW), .T_RD_FULL(TF), .T_RD_PAGE(TP), .T_WR_PULSE(TWP),
                .T_WR_CYCLE(TWC), .T_TURN(TT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .req_len(req_len), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_lb_n(sram_lb_n),
    .sram_ub_n(sram_ub_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ {5'd0, a[18:16]}};
  endfunction

  logic [15:0] mem [int unsigned];
  logic [15:0] exp_mem [int unsigned];

  function automatic logic [15:0] model_rd(input logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_word(a);
  endfunction

  function automatic logic [15:0] exp_rd(input logic [AW-1:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_word(a);
  endfunction

  function automatic logic [15:0] lane_mask(input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : 8'h00, be[0] ? d[7:0] : 8'h00};
  endfunction

  // memory model, evaluated between edges
  int page_age = 0, word_age = 0, we_run = 0, last_pulse = 0, we_pulses = 0, bus_viol = 0;
  logic [AW-1:0] p_addr = '0;
  logic p_sel = 1'b0, p_we_n = 1'b1, p_lb_n = 1'b1, p_ub_n = 1'b1;
  logic [15:0] p_dq = '0;
  logic [15:0] p_dqo_we = '0;

  always @(negedge clk) begin
    logic sel, rd;
    logic [15:0] w;
    sel = !sram_ce1_n && sram_ce2;
    rd  = sel && !sram_oe_n && sram_we_n;
    if (sram_addr[AW-1:4] != p_addr[AW-1:4] || rd != p_sel) page_age = 0;
    else if (page_age < 1000) page_age++;
    if (sram_addr != p_addr || rd != p_sel) word_age = 0;
    else if (word_age < 1000) word_age++;
    if (rd && page_age >= TF - 1 && word_age >= TP - 1) begin
      w = model_rd(sram_addr);
      sram_dq_i <= {sram_ub_n ? 8'hEE : w[15:8], sram_lb_n ? 8'hEE : w[7:0]};
    end else sram_dq_i <= 16'hBAD0;
    if (sram_dq_oe && !sram_oe_n) bus_viol++;
    if (!sram_we_n) begin
      if (we_run > 0 && sram_dq_o != p_dqo_we) bus_viol++;
      if (!sram_dq_oe) bus_viol++;
      we_run++;
      p_dqo_we = sram_dq_o;
    end else if (!p_we_n) begin
      last_pulse = we_run;
      we_pulses++;
      we_run = 0;
      w = model_rd(p_addr);
      if (!p_lb_n) w[7:0] = p_dq[7:0];
      if (!p_ub_n) w[15:8] = p_dq[15:8];
      mem[int'(p_addr)] = w;
    end
    p_addr = sram_addr; p_sel = rd; p_we_n = sram_we_n;
    p_lb_n = sram_lb_n; p_ub_n = sram_ub_n; p_dq = sram_dq_o;
  end

  task automatic chk_standby(input string tag);
    chk(sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && sram_lb_n && sram_ub_n && !sram_dq_oe,
        "R1", tag, {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n, sram_dq_oe},
        7'b1011110);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] be, input logic [3:0] len);
    int t, p0;
    logic [15:0] w;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be; req_len = len;
    while (!req_ready) @(negedge clk);
    p0 = we_pulses;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    chk(!req_ready, "R2", "busy after write accept", req_ready, 0);
    while (!req_ready && t < 500) begin @(negedge clk); t++; end
    chk(t == TWC, "R8", "write cycle length", t, TWC);
    chk(we_pulses - p0 == 1, "R8", "write pulse count", we_pulses - p0, 1);
    chk(last_pulse == TWP, "R8", "write pulse width", last_pulse, TWP);
    chk_standby("standby after write");
    w = exp_rd(a);
    if (be[0]) w[7:0] = d[7:0];
    if (be[1]) w[15:8] = d[15:8];
    exp_mem[int'(a)] = w;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int len, input logic [1:0] be);
    int t, got, tnext, tlast;
    logic [AW-1:0] wa;
    string rq;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_len = 4'(len - 1); req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0; got = 0; wa = a; tnext = TF; tlast = 0; rq = "R3";
    chk(!req_ready, "R2", "busy after read accept", req_ready, 0);
    while (got < len && t < 1000) begin
      if (rsp_valid) begin
        chk(t == tnext, rq, "word capture time", t, tnext);
        chk(rsp_data == lane_mask(exp_rd(wa), be), (be == 2'b11) ? "R6" : "R7",
            "read word data", rsp_data, lane_mask(exp_rd(wa), be));
        got++; tlast = t;
        rq = (wa[3:0] == 4'hF) ? "R5" : "R4";
        tnext = t + ((wa[3:0] == 4'hF) ? TF : TP);
        wa = wa + 1'b1;
      end
      @(negedge clk); t++;
    end
    while (!req_ready && t < 2000) begin
      if (rsp_valid) got++;
      @(negedge clk); t++;
    end
    chk(got == len, "R6", "burst word count", got, len);
    chk(t - tlast == TT, "R9", "turnaround before ready", t - tlast, TT);
    chk_standby("standby after read");
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk_standby("reset state");
    chk(req_ready, "R1", "ready after reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_standby("idle after reset release");

    do_read(19'h00120, 1, 2'b11);
    do_read(19'h00200, 16, 2'b11);
    do_read(19'h0033C, 8, 2'b11);
    do_read(19'h7FFF8, 16, 2'b11);
    do_write(19'h00405, 16'h1234, 2'b11, 4'd0);
    do_write(19'h00405, 16'hAB00, 2'b10, 4'd0);
    do_read(19'h00405, 1, 2'b11);
    do_write(19'h00406, 16'h00CD, 2'b01, 4'd0);
    do_read(19'h00406, 1, 2'b01);
    do_read(19'h00406, 1, 2'b10);
    do_write(19'h0050E, 16'h5A5A, 2'b11, 4'd9);
    do_read(19'h0050E, 4, 2'b11);

    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      logic [1:0] be;
      a  = 19'h12340 + 19'($urandom % 64);
      be = 2'($urandom % 3 + 1);
      if ($urandom % 2 == 0) do_write(a, 16'($urandom), be, 4'($urandom));
      else do_read(a, int'($urandom % 16) + 1, be);
    end

    chk(bus_viol == 0, "R9", "bus drive or contention violations", bus_viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule